// File: doc/BRIEF.md
# Masked Odd-Lane Duplicate Unit

This block is one execution lane of a vector unit. It takes a source vector of up to 512 bits, seen as sixteen 32-bit elements. Within every pair of neighbouring elements it copies the upper (odd-indexed) element into both slots of that pair. The result is merged into an image of the destination register. How it is merged depends on which of three encoding modes issued the operation, the selected vector length, and a per-element write mask that can either keep or zero the unselected elements.

The unit also checks a 4-bit reserved register field. The two prefixed modes require this field to be all ones. When it is not, the unit raises an undefined-opcode fault and returns the old destination unchanged. Element bits are moved as raw bit patterns, so no floating-point condition is ever detected or reported. Each accepted operation produces its result exactly one clock later.

Top module: `odd_lane_dup`

## Requirements
- R1: For every element pair (2k, 2k+1) that is written, both destination elements receive source element 2k+1, copied bit-for-bit.
- R2: With `mode_sel` = 0 (legacy), elements 0 to 3 receive the duplicated values and bits 511:128 keep `old_dst`. `vlen_sel`, `wmask`, `mask_en` and `zero_mask` have no effect, and no fault is ever raised.
- R3: With `mode_sel` = 1 (compact prefix), the length is 128 bits when `vlen_sel` = 0 and 256 bits otherwise. All active elements are written regardless of the mask inputs, and every bit above the length is zero.
- R4: With `mode_sel` = 2 or 3 (extended prefix), `vlen_sel` 0, 1 and 2 or 3 select 4, 8 and 16 active elements respectively. Every bit above the selected length is zero.
- R5: In extended mode, active element j takes the duplicated value when `wmask[j]` is 1 or `mask_en` is 0.
- R6: In extended mode, an active element whose mask bit is 0 while `mask_en` is 1 keeps `old_dst` when `zero_mask` = 0 and becomes zero when `zero_mask` = 1.
- R7: When `mode_sel` is not 0 and `rsvd_field` is not 4'hF, `ud_fault` is 1 and `new_dst` equals `old_dst`. Otherwise `ud_fault` is 0.
- R8: NaN, infinity and denormal bit patterns pass through unaltered. The unit has no exception output.
- R9: `out_valid`, `new_dst` and `ud_fault` reflect an operation one clock after `in_valid` is sampled high. `out_valid` is 0 after any cycle without `in_valid`, and `new_dst` and `ud_fault` then hold. A synchronous active-high `rst` clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Current destination register image |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 |
| mode_sel | input | 2 | 0 legacy, 1 compact prefix, 2/3 extended prefix |
| wmask | input | 16 | Per-element write mask |
| mask_en | input | 1 | Write mask in use (extended mode) |
| zero_mask | input | 1 | 1 zeroes unselected elements, 0 merges |
| rsvd_field | input | 4 | Reserved register field, must be 4'hF in prefixed modes |
| out_valid | output | 1 | Result present |
| new_dst | output | 512 | New destination register image |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The case that is hardest to reach from the ports is an extended-mode operation where masking is on, some mask bits are clear and the reserved field is valid. It must also use a length other than 512, so that merging, zeroing and upper clearing all act on the same result. Uniform random stimulus seldom hits this together with a valid reserved field. The stimulus therefore gives the reserved field the value 4'hF three times in four, and draws masks, length and zeroing independently. Directed vectors are added for each mode at each length, and for NaN and denormal patterns.

// File: rtl/odd_lane_dup.sv
module odd_lane_dup #(
  parameter int ELEM_W    = 32,
  parameter int MAX_ELEMS = 16,
  localparam int VEC_W    = ELEM_W * MAX_ELEMS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [VEC_W-1:0]     src,
  input  logic [VEC_W-1:0]     old_dst,
  input  logic [1:0]           vlen_sel,
  input  logic [1:0]           mode_sel,
  input  logic [MAX_ELEMS-1:0] wmask,
  input  logic                 mask_en,
  input  logic                 zero_mask,
  input  logic [3:0]           rsvd_field,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     new_dst,
  output logic                 ud_fault
);
  localparam int CNT_W      = $clog2(MAX_ELEMS + 1);
  localparam int BASE_ELEMS = MAX_ELEMS / 4;

  logic             is_legacy, is_compact, fault_c;
  logic [CNT_W-1:0] n_act;
  logic [VEC_W-1:0] shaped, next_dst;

  assign is_legacy  = (mode_sel == 2'd0);
  assign is_compact = (mode_sel == 2'd1);
  assign fault_c    = !is_legacy && (rsvd_field != 4'hF);

  always_comb begin
    if (is_legacy || vlen_sel == 2'd0) n_act = CNT_W'(BASE_ELEMS);
    else if (is_compact || vlen_sel == 2'd1) n_act = CNT_W'(2 * BASE_ELEMS);
    else n_act = CNT_W'(MAX_ELEMS);
  end

  for (genvar j = 0; j < MAX_ELEMS; j++) begin : g_el
    localparam int HI = j | 1;
    logic [ELEM_W-1:0] dup, old, res;
    logic active, take;
    assign dup    = src[HI*ELEM_W +: ELEM_W];
    assign old    = old_dst[j*ELEM_W +: ELEM_W];
    assign active = CNT_W'(j) < n_act;
    assign take   = is_compact || !mask_en || wmask[j];
    always_comb begin
      if (is_legacy) res = active ? dup : old;
      else if (!active) res = '0;
      else if (take) res = dup;
      else res = zero_mask ? '0 : old;
    end
    assign shaped[j*ELEM_W +: ELEM_W] = res;
  end

  assign next_dst = fault_c ? old_dst : shaped;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ud_fault  <= 1'b0;
      new_dst   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ud_fault <= fault_c;
        new_dst  <= next_dst;
      end
    end
  end
endmodule

module odd_lane_dup_chk #(
  parameter int ELEM_W    = 32,
  parameter int MAX_ELEMS = 16,
  localparam int VEC_W    = ELEM_W * MAX_ELEMS,
  localparam int BASE_W   = VEC_W / 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [VEC_W-1:0]     src,
  input logic [VEC_W-1:0]     old_dst,
  input logic [1:0]           vlen_sel,
  input logic [1:0]           mode_sel,
  input logic [MAX_ELEMS-1:0] wmask,
  input logic                 mask_en,
  input logic                 zero_mask,
  input logic [3:0]           rsvd_field,
  input logic                 out_valid,
  input logic [VEC_W-1:0]     new_dst,
  input logic                 ud_fault
);
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(new_dst) && $stable(ud_fault));
  p_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel != 2'd0 && rsvd_field != 4'hF)
      |=> ud_fault && new_dst == $past(old_dst));
  p_legacy_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd0)
      |=> !ud_fault && new_dst[VEC_W-1:BASE_W] == $past(old_dst[VEC_W-1:BASE_W]));
  p_compact_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd1 && rsvd_field == 4'hF)
      |=> new_dst[VEC_W-1:2*BASE_W] == '0);
  p_ext_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel[1] && rsvd_field == 4'hF && vlen_sel == 2'd0)
      |=> new_dst[VEC_W-1:BASE_W] == '0);
  p_dup_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd0)
      |=> new_dst[ELEM_W-1:0] == $past(src[2*ELEM_W-1:ELEM_W])
       && new_dst[2*ELEM_W-1:ELEM_W] == $past(src[2*ELEM_W-1:ELEM_W]));
  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel[1] && rsvd_field == 4'hF && mask_en && zero_mask && !wmask[0])
      |=> new_dst[ELEM_W-1:0] == '0);
endmodule

bind odd_lane_dup odd_lane_dup_chk #(.ELEM_W(ELEM_W), .MAX_ELEMS(MAX_ELEMS)) u_chk (.*);

// File: tb/odd_lane_dup_test.sv
module odd_lane_dup_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic         clk = 1'b0;
  logic         rst, in_valid, mask_en, zero_mask;
  logic [511:0] src, old_dst;
  logic [1:0]   vlen_sel, mode_sel;
  logic [15:0]  wmask;
  logic [3:0]   rsvd_field;
  logic         out_valid, ud_fault;
  logic [511:0] new_dst;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  odd_lane_dup uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .vlen_sel(vlen_sel), .mode_sel(mode_sel), .wmask(wmask), .mask_en(mask_en),
    .zero_mask(zero_mask), .rsvd_field(rsvd_field), .out_valid(out_valid),
    .new_dst(new_dst), .ud_fault(ud_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [512:0] model(
      input logic [511:0] s, input logic [511:0] o, input logic [1:0] vl,
      input logic [1:0] md, input logic [15:0] m, input logic men,
      input logic zm, input logic [3:0] rf);
    logic [511:0] d;
    int n;
    if (md != 2'd0 && rf != 4'hF) return {1'b1, o};
    if (md == 2'd0) n = 4;
    else if (md == 2'd1) n = (vl == 2'd0) ? 4 : 8;
    else n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    for (int j = 0; j < 16; j++) begin
      logic [31:0] dv, ov, r;
      dv = s[(j | 1)*32 +: 32];
      ov = o[j*32 +: 32];
      if (md == 2'd0) r = (j < 4) ? dv : ov;
      else if (j >= n) r = '0;
      else if (md == 2'd1 || !men || m[j]) r = dv;
      else r = zm ? 32'd0 : ov;
      d[j*32 +: 32] = r;
    end
    return {1'b0, d};
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic apply(input string tag, input logic [511:0] s, input logic [511:0] o,
                       input logic [1:0] vl, input logic [1:0] md, input logic [15:0] m,
                       input logic men, input logic zm, input logic [3:0] rf);
    logic [512:0] exp;
    src = s; old_dst = o; vlen_sel = vl; mode_sel = md; wmask = m;
    mask_en = men; zero_mask = zm; rsvd_field = rf; in_valid = 1'b1;
    exp = model(s, o, vl, md, m, men, zm, rf);
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b1 || ud_fault !== exp[512] || new_dst !== exp[511:0]) begin
      n_bad++;
      $display("FAIL %s: actual v=%b f=%b d=%h expected v=1 f=%b d=%h",
               tag, out_valid, ud_fault, new_dst, exp[512], exp[511:0]);
    end
  endtask

  initial begin
    logic [511:0] s0, o0, nan_src;
    logic [1:0] md;
    string tag;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; src = '0; old_dst = '0; vlen_sel = '0;
    mode_sel = '0; wmask = '0; mask_en = 1'b0; zero_mask = 1'b0; rsvd_field = 4'hF;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || ud_fault !== 1'b0 || new_dst !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: actual v=%b f=%b expected v=0 f=0 d=0", out_valid, ud_fault);
    end
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      s0[i*32 +: 32] = 32'h1000_0000 + i;
      o0[i*32 +: 32] = 32'hA000_0000 + i;
    end
    apply("R1 R2 legacy", s0, o0, 2'd2, 2'd0, 16'h0000, 1'b1, 1'b1, 4'h0);
    apply("R2 legacy masks ignored", s0, o0, 2'd3, 2'd0, 16'h5555, 1'b1, 1'b0, 4'h3);
    apply("R3 compact 128", s0, o0, 2'd0, 2'd1, 16'h0000, 1'b1, 1'b1, 4'hF);
    apply("R3 compact 256", s0, o0, 2'd1, 2'd1, 16'h0000, 1'b1, 1'b1, 4'hF);
    apply("R3 compact sel 512", s0, o0, 2'd2, 2'd1, 16'h0000, 1'b1, 1'b0, 4'hF);
    apply("R4 ext 128", s0, o0, 2'd0, 2'd2, 16'hFFFF, 1'b1, 1'b0, 4'hF);
    apply("R4 ext 256", s0, o0, 2'd1, 2'd3, 16'hFFFF, 1'b1, 1'b0, 4'hF);
    apply("R4 ext 512", s0, o0, 2'd3, 2'd2, 16'hFFFF, 1'b1, 1'b0, 4'hF);
    apply("R5 mask disabled", s0, o0, 2'd2, 2'd2, 16'h0000, 1'b0, 1'b1, 4'hF);
    apply("R5 R6 merging", s0, o0, 2'd2, 2'd2, 16'hA5C3, 1'b1, 1'b0, 4'hF);
    apply("R5 R6 zeroing", s0, o0, 2'd1, 2'd2, 16'h3C96, 1'b1, 1'b1, 4'hF);
    apply("R7 compact fault", s0, o0, 2'd1, 2'd1, 16'hFFFF, 1'b0, 1'b0, 4'hE);
    apply("R7 ext fault", s0, o0, 2'd2, 2'd3, 16'hFFFF, 1'b0, 1'b0, 4'h7);
    apply("R7 legacy no fault", s0, o0, 2'd0, 2'd0, 16'h0, 1'b0, 1'b0, 4'h0);
    for (int i = 0; i < 16; i++)
      nan_src[i*32 +: 32] = (i % 4 == 1) ? 32'h7FC0_0001 : (i % 4 == 3) ? 32'h0000_0001 :
                            (i % 4 == 0) ? 32'hFF80_0000 : 32'h8000_0003;
    apply("R8 special patterns", nan_src, o0, 2'd2, 2'd2, 16'hFFFF, 1'b0, 1'b0, 4'hF);
    apply("R8 special legacy", nan_src, o0, 2'd0, 2'd0, 16'h0, 1'b0, 1'b0, 4'hF);

    in_valid = 1'b0; src = rnd512(); old_dst = rnd512(); mode_sel = 2'd2;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || new_dst !== model(nan_src, o0, 2'd0, 2'd0, 16'h0, 1'b0, 1'b0, 4'hF)) begin
      n_bad++;
      $display("FAIL R9 idle hold: actual v=%b d=%h expected v=0 held", out_valid, new_dst);
    end

    for (int k = 0; k < 400; k++) begin
      md = 2'($urandom_range(0, 3));
      tag = (md == 2'd0) ? "R2 random" : (md == 2'd1) ? "R3 random" : "R4 R5 R6 random";
      apply(tag, rnd512(), rnd512(), 2'($urandom_range(0, 3)), md, 16'($urandom),
            1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) != 0) ? 4'hF : 4'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule